// File: doc/BRIEF.md
# Pixel Color Component Extractor

This block sits between a framebuffer fetch path and a display timing generator. Each cycle it takes one raw pixel word and produces registered 8-bit red, green and blue values. A format word sets how many bytes of the pixel word are meaningful. Three selection words, one per color, give the position of the lowest bit of that component, how many bits it spans, and a fallback value.

A component field narrower than eight bits is widened to full scale by repeating its top bits into the low bits. A wider field is reduced to its eight most significant bits. The fallback value replaces a component when that component's length is zero, when the timing generator reports a position outside the visible area, or when the pixel supply runs dry. A pixel supply that runs dry means either an asserted underrun flag or a missing pixel during the visible area. Software can therefore make starved pixels visible, for example by setting the red fallback to full scale.

All three outputs and a delayed copy of the active-area flag appear one clock after their inputs, so they stay aligned downstream.

Top module: `pix_comp_extract`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three color outputs become 0x00 and `active_o` becomes 0.
- R2: Outputs change only at a rising clock edge and reflect the inputs sampled at the previous edge (latency of one cycle); `active_o` equals `in_active` delayed by one cycle.
- R3: Bits [4:3] of `fmt_word` hold bytes-per-pixel minus one (0 means one byte); pixel bits at or above bytes×8 read as zero before any extraction.
- R4: In each selection word, bits [4:0] give the lowest extracted bit, bits [11:8] the field length, and bits [23:16] the fallback value; pixel bits beyond bit 31 read as zero.
- R5: A field length from 1 to 7 is left-aligned into the 8-bit output, with its bits repeated from the top into the remaining low bits.
- R6: A field length of 8 outputs the field unchanged; a length from 9 to 15 outputs the field's 8 most significant bits.
- R7: A component whose field length is zero outputs its own fallback value; the other components are unaffected.
- R8: When `in_active` is low, all three components output their fallback values.
- R9: When `underrun` is high, all three components output their fallback values (a red fallback of 0xFF shows starved pixels as red).
- R10: When `pix_valid` is low while `in_active` is high, the pixel counts as missing and all three components output their fallback values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_word | input | 32 | Raw pixel word from the framebuffer path |
| pix_valid | input | 1 | Pixel word is present this cycle |
| in_active | input | 1 | Timing generator reports the visible area |
| underrun | input | 1 | Pixel buffer has run dry |
| fmt_word | input | 32 | Format word; bits [4:3] hold bytes per pixel minus one |
| sel_red_word | input | 32 | Red selection: lowest bit, length, fallback |
| sel_grn_word | input | 32 | Green selection: lowest bit, length, fallback |
| sel_blu_word | input | 32 | Blue selection: lowest bit, length, fallback |
| red_o | output | 8 | Registered red component |
| grn_o | output | 8 | Registered green component |
| blu_o | output | 8 | Registered blue component |
| active_o | output | 1 | Active-area flag aligned with the color outputs |

## Verification
The checker checks on every cycle that each fallback condition leads to the fallback byte one cycle later. These conditions are a zero length per color, the inactive area, an underrun and a missing pixel. It also checks that the active flag is delayed by exactly one cycle. Extracting actual field contents cannot be expressed as a simple property without copying the datapath. The bench scenarios therefore carry the arithmetic cases: byte-width masking, short fields with bit repetition, long fields truncated to their top bits, and fields that run past the top of the pixel word. Reset values and the absence of any change before the clock edge are also shown only by directed bench steps.

// File: rtl/pce_pkg.sv
// Shared constants and types for the pixel color component extractor.
// Assumes 32-bit configuration words and three color channels.
package pce_pkg;
    localparam int CFG_W     = 32;
    localparam int OUT_W     = 8;
    localparam int LEN_W     = 4;
    localparam int LSB_W     = 5;
    localparam int DFLT_W    = 8;
    localparam int NUM_COMP  = 3;

    // Field positions inside the configuration words
    localparam int FMT_BPP_POS = 3;
    localparam int SEL_LSB_POS = 0;
    localparam int SEL_LEN_POS = 8;
    localparam int SEL_DFL_POS = 16;

    // Channel order inside packed component arrays
    localparam int CH_RED = 0;
    localparam int CH_GRN = 1;
    localparam int CH_BLU = 2;

    typedef struct packed {
        logic [DFLT_W-1:0] dflt;
        logic [LEN_W-1:0]  len;
        logic [LSB_W-1:0]  lsb;
    } comp_sel_t;
endpackage

// File: rtl/pce_width_mask.sv
// Clears every pixel byte above the configured bytes-per-pixel.
// Assumes PIX_BYTES >= 2 so the byte-count code has a nonzero width.
module pce_width_mask #(
    parameter int PIX_BYTES = 4,
    localparam int PIX_W    = PIX_BYTES * 8,
    localparam int BPP_W    = (PIX_BYTES > 1) ? $clog2(PIX_BYTES) : 1
) (
    input  logic [PIX_W-1:0] pix_word,
    input  logic [BPP_W-1:0] bpp_code,
    output logic [PIX_W-1:0] pix_masked
);
    // Per byte lane: keep the lane only if it lies inside the pixel width
    for (genvar b = 0; b < PIX_BYTES; b++) begin : g_lane
        assign pix_masked[b*8 +: 8] = (b <= int'(bpp_code)) ? pix_word[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/pce_field_unit.sv
// Extracts one color component from a masked pixel word.
// Field bits above the pixel word read as zero. Short fields are widened
// by repeating their top bits; long fields keep their top OUT_W bits.
// The fallback value wins when forced or when the length is zero.
module pce_field_unit
    import pce_pkg::*;
#(
    parameter int PIX_W = 32,
    localparam int EXT_W = PIX_W + (1 << LEN_W)
) (
    input  logic [PIX_W-1:0] pix_masked,
    input  comp_sel_t        sel,
    input  logic             force_dflt,
    output logic [OUT_W-1:0] comp
);
    logic [EXT_W-1:0] shifted;
    logic [EXT_W-1:0] field;
    logic [EXT_W-1:0] hi_part;
    logic [OUT_W-1:0] aligned;
    logic [OUT_W-1:0] repl;
    int               len_i;
    int               left_sh;

    // Isolate the field, zero-extended above the pixel word
    always_comb begin
        shifted = {{(EXT_W-PIX_W){1'b0}}, pix_masked} >> sel.lsb;
        field   = shifted & ~({EXT_W{1'b1}} << sel.len);
    end

    // Long fields: keep the most significant OUT_W bits
    always_comb begin
        len_i   = int'(sel.len);
        hi_part = (len_i >= OUT_W) ? (field >> (len_i - OUT_W)) : '0;
    end

    // Short fields: left-align then fill low bits with repeated copies
    always_comb begin
        left_sh = (len_i < OUT_W) ? (OUT_W - len_i) : 0;
        aligned = field[OUT_W-1:0] << left_sh;
        repl    = aligned;
        for (int j = 1; j < OUT_W; j++) begin
            repl = repl | (aligned >> (j * len_i));
        end
    end

    // Final choice between fallback, truncated and widened value
    always_comb begin
        if (force_dflt || (sel.len == '0))
            comp = sel.dflt;
        else if (len_i >= OUT_W)
            comp = hi_part[OUT_W-1:0];
        else
            comp = repl;
    end
endmodule

// File: rtl/pce_out_reg.sv
// Output stage: registers all color components and the active flag.
// Synchronous active-low reset clears everything.
module pce_out_reg
    import pce_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_COMP-1:0][OUT_W-1:0]   comp_d,
    input  logic                             active_d,
    output logic [NUM_COMP-1:0][OUT_W-1:0]   comp_q,
    output logic                             active_q
);
    // One-cycle pipeline register for data and alignment flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comp_q   <= '0;
            active_q <= 1'b0;
        end else begin
            comp_q   <= comp_d;
            active_q <= active_d;
        end
    end
endmodule

// File: rtl/pix_comp_extract.sv
// Top of the pixel color component extractor.
// Decodes the configuration words, masks the pixel to its byte width,
// extracts three components in parallel and registers them with the
// active flag. Configuration words are assumed stable while in use.
module pix_comp_extract
    import pce_pkg::*;
#(
    parameter int PIX_BYTES = 4,
    localparam int PIX_W    = PIX_BYTES * 8,
    localparam int BPP_W    = (PIX_BYTES > 1) ? $clog2(PIX_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_word,
    input  logic              pix_valid,
    input  logic              in_active,
    input  logic              underrun,
    input  logic [CFG_W-1:0]  fmt_word,
    input  logic [CFG_W-1:0]  sel_red_word,
    input  logic [CFG_W-1:0]  sel_grn_word,
    input  logic [CFG_W-1:0]  sel_blu_word,
    output logic [OUT_W-1:0]  red_o,
    output logic [OUT_W-1:0]  grn_o,
    output logic [OUT_W-1:0]  blu_o,
    output logic              active_o
);
    logic [CFG_W-1:0]                 sel_words [NUM_COMP];
    comp_sel_t                        sel_arr   [NUM_COMP];
    logic [NUM_COMP-1:0][OUT_W-1:0]   comp_d;
    logic [NUM_COMP-1:0][OUT_W-1:0]   comp_q;
    logic [PIX_W-1:0]                 pix_masked;
    logic                             force_dflt;
    logic                             unused_cfg;

    // Configuration bits outside the decoded fields are ignored
    assign unused_cfg = ^{fmt_word, sel_red_word, sel_grn_word, sel_blu_word};

    // Gather selection words in channel order
    assign sel_words[CH_RED] = sel_red_word;
    assign sel_words[CH_GRN] = sel_grn_word;
    assign sel_words[CH_BLU] = sel_blu_word;

    // Fallback for the whole pixel: outside visible area or starved supply
    assign force_dflt = !in_active || underrun || !pix_valid;

    pce_width_mask #(.PIX_BYTES(PIX_BYTES)) u_mask (
        .pix_word   (pix_word),
        .bpp_code   (fmt_word[FMT_BPP_POS +: BPP_W]),
        .pix_masked (pix_masked)
    );

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_chan
        // Decode this channel's selection word
        assign sel_arr[c].lsb  = sel_words[c][SEL_LSB_POS +: LSB_W];
        assign sel_arr[c].len  = sel_words[c][SEL_LEN_POS +: LEN_W];
        assign sel_arr[c].dflt = sel_words[c][SEL_DFL_POS +: DFLT_W];

        pce_field_unit #(.PIX_W(PIX_W)) u_field (
            .pix_masked (pix_masked),
            .sel        (sel_arr[c]),
            .force_dflt (force_dflt),
            .comp       (comp_d[c])
        );
    end

    pce_out_reg u_oreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .comp_d   (comp_d),
        .active_d (in_active),
        .comp_q   (comp_q),
        .active_q (active_o)
    );

    assign red_o = comp_q[CH_RED];
    assign grn_o = comp_q[CH_GRN];
    assign blu_o = comp_q[CH_BLU];
endmodule

// File: rtl/pce_checker.sv
// Cycle properties for pix_comp_extract, attached with bind.
module pce_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        pix_valid,
    input logic        in_active,
    input logic        underrun,
    input logic [31:0] sel_red_word,
    input logic [31:0] sel_grn_word,
    input logic [31:0] sel_blu_word,
    input logic [7:0]  red_o,
    input logic [7:0]  grn_o,
    input logic [7:0]  blu_o,
    input logic        active_o
);
    logic unused_chk;
    assign unused_chk = ^{sel_red_word, sel_grn_word, sel_blu_word};

    // R2: active flag delayed by exactly one cycle
    p_active_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (active_o == $past(in_active)));

    // R7: zero length gives that channel's fallback
    p_red_len0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(sel_red_word[11:8]) == 4'd0))
        |-> (red_o == $past(sel_red_word[23:16])));
    p_grn_len0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(sel_grn_word[11:8]) == 4'd0))
        |-> (grn_o == $past(sel_grn_word[23:16])));
    p_blu_len0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(sel_blu_word[11:8]) == 4'd0))
        |-> (blu_o == $past(sel_blu_word[23:16])));

    // R8: outside the visible area all channels fall back
    p_inactive_dflt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_active))
        |-> ((red_o == $past(sel_red_word[23:16])) &&
             (grn_o == $past(sel_grn_word[23:16])) &&
             (blu_o == $past(sel_blu_word[23:16]))));

    // R9: underrun makes all channels fall back
    p_underrun_dflt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(underrun))
        |-> ((red_o == $past(sel_red_word[23:16])) &&
             (grn_o == $past(sel_grn_word[23:16])) &&
             (blu_o == $past(sel_blu_word[23:16]))));

    // R10: missing pixel inside the visible area falls back
    p_missing_dflt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_active) && !$past(pix_valid))
        |-> ((red_o == $past(sel_red_word[23:16])) &&
             (grn_o == $past(sel_grn_word[23:16])) &&
             (blu_o == $past(sel_blu_word[23:16]))));
endmodule

bind pix_comp_extract pce_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_valid    (pix_valid),
    .in_active    (in_active),
    .underrun     (underrun),
    .sel_red_word (sel_red_word),
    .sel_grn_word (sel_grn_word),
    .sel_blu_word (sel_blu_word),
    .red_o        (red_o),
    .grn_o        (grn_o),
    .blu_o        (blu_o),
    .active_o     (active_o)
);

// File: tb/pix_comp_extract_tb_top.sv
// Self-checking bench: vector table walk, then directed reset/latency tests.
module pix_comp_extract_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] F4 = 32'h18;
    localparam logic [31:0] F2 = 32'h08;
    localparam logic [31:0] F1 = 32'h00;

    typedef struct packed {
        logic [31:0] fmt;
        logic [31:0] sr;
        logic [31:0] sg;
        logic [31:0] sb;
        logic [31:0] pix;
        logic        act;
        logic        ur;
        logic        vld;
        logic [7:0]  er;
        logic [7:0]  eg;
        logic [7:0]  eb;
        logic [7:0]  req;
    } vec_t;

    // Selection word: fallback [23:16], length [11:8], lowest bit [4:0]
    function automatic logic [31:0] mk(input logic [7:0] d, input logic [3:0] l, input logic [4:0] s);
        return {8'h00, d, 4'h0, l, 3'h0, s};
    endfunction

    localparam vec_t VEC [10] = '{
        '{F4, mk(8'h00,4'd8,5'd16), mk(8'h00,4'd8,5'd8), mk(8'h00,4'd8,5'd0), 32'h00123456, 1'b1,1'b0,1'b1, 8'h12,8'h34,8'h56, 8'd4},  // R4
        '{F2, mk(8'h00,4'd5,5'd11), mk(8'h00,4'd6,5'd5), mk(8'h00,4'd5,5'd0), 32'hFFFF8410, 1'b1,1'b0,1'b1, 8'h84,8'h82,8'h84, 8'd5},  // R5 + R3 mask
        '{F1, mk(8'h55,4'd8,5'd8),  mk(8'h00,4'd8,5'd0), mk(8'h00,4'd4,5'd4), 32'hFFFFFF3C, 1'b1,1'b0,1'b1, 8'h00,8'h3C,8'h33, 8'd3},  // R3
        '{F4, mk(8'h00,4'd12,5'd0), mk(8'h00,4'd10,5'd4),mk(8'h00,4'd15,5'd24),32'hF0000ABC, 1'b1,1'b0,1'b1, 8'hAB,8'h2A,8'h01, 8'd6},  // R6
        '{F4, mk(8'h11,4'd0,5'd0),  mk(8'h00,4'd8,5'd0), mk(8'hEE,4'd0,5'd5), 32'h00000077, 1'b1,1'b0,1'b1, 8'h11,8'h77,8'hEE, 8'd7},  // R7
        '{F4, mk(8'h10,4'd8,5'd16), mk(8'h20,4'd8,5'd8), mk(8'h30,4'd8,5'd0), 32'h00123456, 1'b0,1'b0,1'b1, 8'h10,8'h20,8'h30, 8'd8},  // R8
        '{F4, mk(8'hFF,4'd8,5'd16), mk(8'h00,4'd8,5'd8), mk(8'h00,4'd8,5'd0), 32'h00123456, 1'b1,1'b1,1'b1, 8'hFF,8'h00,8'h00, 8'd9},  // R9
        '{F4, mk(8'h10,4'd8,5'd16), mk(8'h20,4'd8,5'd8), mk(8'h30,4'd8,5'd0), 32'h00123456, 1'b1,1'b0,1'b0, 8'h10,8'h20,8'h30, 8'd10}, // R10
        '{F4, mk(8'h00,4'd1,5'd31), mk(8'h00,4'd3,5'd0), mk(8'h00,4'd2,5'd30),32'h80000000, 1'b1,1'b0,1'b1, 8'hFF,8'h00,8'hAA, 8'd5},  // R5
        '{F4, mk(8'h00,4'd7,5'd0),  mk(8'h00,4'd3,5'd0), mk(8'h00,4'd4,5'd0), 32'h00000005, 1'b1,1'b0,1'b1, 8'h0A,8'hB6,8'h55, 8'd5}   // R5
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pix_word, fmt_word, sel_red_word, sel_grn_word, sel_blu_word;
    logic        pix_valid, in_active, underrun;
    logic [7:0]  red_o, grn_o, blu_o;
    logic        active_o;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_comp_extract dut_i (
        .clk(clk), .rst_n(rst_n), .pix_word(pix_word), .pix_valid(pix_valid),
        .in_active(in_active), .underrun(underrun), .fmt_word(fmt_word),
        .sel_red_word(sel_red_word), .sel_grn_word(sel_grn_word), .sel_blu_word(sel_blu_word),
        .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o), .active_o(active_o)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        fmt_word = v.fmt; sel_red_word = v.sr; sel_grn_word = v.sg; sel_blu_word = v.sb;
        pix_word = v.pix; in_active = v.act; underrun = v.ur; pix_valid = v.vld;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        apply(VEC[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(red_o, 8'h00, "R1", "red after reset");
        chk(grn_o, 8'h00, "R1", "grn after reset");
        chk(blu_o, 8'h00, "R1", "blu after reset");
        chk({7'd0, active_o}, 8'h00, "R1", "active after reset");
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 10; i++) begin
            string tag;
            apply(VEC[i]);
            @(posedge clk);
            @(negedge clk);
            tag = $sformatf("R%0d", VEC[i].req);
            chk(red_o, VEC[i].er, tag, $sformatf("vec %0d red", i));
            chk(grn_o, VEC[i].eg, tag, $sformatf("vec %0d grn", i));
            chk(blu_o, VEC[i].eb, tag, $sformatf("vec %0d blu", i));
            chk({7'd0, active_o}, {7'd0, VEC[i].act}, "R2", $sformatf("vec %0d active", i));
        end

        // R2: no change before the edge, new value one cycle later
        apply(VEC[0]);
        @(posedge clk);
        @(negedge clk);
        apply(VEC[5]);
        #1;
        chk(red_o, 8'h12, "R2", "red held before edge");
        chk({7'd0, active_o}, 8'h01, "R2", "active held before edge");
        @(posedge clk);
        @(negedge clk);
        chk(red_o, 8'h10, "R2", "red after edge");
        chk({7'd0, active_o}, 8'h00, "R2", "active after edge");

        // R3: same pixel, wider format exposes the upper byte
        apply(VEC[2]);
        fmt_word = F2;
        @(posedge clk);
        @(negedge clk);
        chk(red_o, 8'hFF, "R3", "red with two-byte width");

        // R1: reset asserted mid-run
        apply(VEC[0]);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(red_o, 8'h00, "R1", "red mid-run reset");
        chk(blu_o, 8'h00, "R1", "blu mid-run reset");
        chk({7'd0, active_o}, 8'h00, "R1", "active mid-run reset");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(grn_o, 8'h34, "R4", "grn after reset release");

        finish_run();
    end
endmodule